// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block produces the nominal bit timing grid for a CAN-style controller. A single 16-bit configuration word sets three values: a 6-bit divider value, the length of the segment before the sample point, and the length of the segment after it. A divider turns the system clock into time-quantum ticks. A quantum index then steps through each bit: a one-quantum synchronisation slot, the first timing segment, and the second timing segment.

The block drives four one-clock strobes: every quantum, the start of each bit, the transmit point and the sample point. It also raises an error flag when the configured lengths form a combination that cannot be used. The configuration is captured only while the block is disabled. An invalid configuration keeps every strobe low.

Top module: `can_bit_timing`

## Requirements
- R1: With divider value P in cfg_word[5:0], tq_tick pulses for one clock every 2*(P+1) system clocks while running.
- R2: The first segment value A sits in cfg_word[11:8] and the second segment value B in cfg_word[14:12]; each segment lasts its value plus one quanta.
- R3: bit_start pulses for one clock at the start of each synchronisation quantum, and its period is 2*(P+1)*(3+A+B) system clocks.
- R4: sample_pt pulses at the start of the first quantum of the second segment, (A+2) quanta after bit_start.
- R5: tx_pt pulses at the start of the first quantum of the first segment, one quantum after bit_start.
- R6: A configuration is valid only when 3 <= A <= 15, 1 <= B <= 7, A > B, and P is nonzero whenever B = 1. cfg_err is 1 exactly when the captured configuration is invalid.
- R7: While enable is low or the configuration is invalid, tq_tick, bit_start, tx_pt and sample_pt stay low.
- R8: cfg_word is captured only while enable is low. Changes to it while enable is high have no effect on timing or on cfg_err.
- R9: During reset all outputs are low. Each of bit_start, tx_pt and sample_pt coincides with a tq_tick, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the timing grid; low allows a new configuration to be captured |
| cfg_word | input | 16 | Divider in [5:0], first segment in [11:8], second segment in [14:12] |
| tq_tick | output | 1 | One-clock pulse at the start of every quantum |
| bit_start | output | 1 | One-clock pulse at the start of every bit |
| tx_pt | output | 1 | One-clock pulse at the transmit point |
| sample_pt | output | 1 | One-clock pulse at the sample point |
| cfg_err | output | 1 | Captured configuration is not allowed |

## Verification
On every cycle the assertions check the strobe relationships. The bit strobes always fall on a quantum tick and are mutually exclusive. Quantum ticks never come back to back. Everything stays quiet while the block is disabled or flagged in error. Those checks cannot show that the tick spacing, the bit period and the sample and transmit offsets match the configured fields. That takes the bench's sweep, which measures these intervals in clocks for each setting. The bench scenarios also exercise the validity rule against hand-chosen legal and illegal combinations. They show that a configuration written while running is ignored.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int BRP_W    = 6;
  localparam int TS1_W    = 4;
  localparam int TS2_W    = 3;
  localparam int CFG_W    = 16;
  localparam int BRP_LSB  = 0;
  localparam int TS1_LSB  = 8;
  localparam int TS2_LSB  = 12;
  localparam int TS1_MIN  = 3;
  localparam int TS2_MIN  = 1;
  localparam int SYNC_Q   = 1;
  localparam int MAX_BITQ = SYNC_Q + (2 ** TS1_W) + (2 ** TS2_W);
  localparam int QW       = $clog2(MAX_BITQ + 1);
  localparam int DIV_W    = BRP_W + 1;

  typedef struct packed {
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [BRP_W-1:0] brp;
  } btg_cfg_t;
endpackage

// File: rtl/btg_cfg_chk.sv
module btg_cfg_chk
  import btg_pkg::*;
(
  input  btg_cfg_t cfg,
  output logic     valid
);
  logic ts1_ok, ts2_ok, order_ok, div_ok;

  always_comb begin
    ts1_ok   = (int'(cfg.ts1) >= TS1_MIN);
    ts2_ok   = (int'(cfg.ts2) >= TS2_MIN);
    order_ok = (int'(cfg.ts1) > int'(cfg.ts2));
    div_ok   = (int'(cfg.ts2) != TS2_MIN) || (cfg.brp != '0);
    valid    = ts1_ok && ts2_ok && order_ok && div_ok;
  end
endmodule

// File: rtl/btg_prescaler.sv
module btg_prescaler
  import btg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [BRP_W-1:0] brp,
  output logic             q_first,
  output logic             q_last
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit   = {brp, 1'b1};
  assign q_first = run && (cnt == '0);
  assign q_last  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/btg_seg_seq.sv
module btg_seg_seq
  import btg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             q_last,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  output logic [QW-1:0]    q_idx
);
  logic [QW-1:0] last_idx;

  assign last_idx = QW'(SYNC_Q + 1) + QW'(ts1) + QW'(ts2);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      q_idx <= '0;
    end else if (q_last) begin
      q_idx <= (q_idx == last_idx) ? '0 : q_idx + 1'b1;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import btg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             tq_tick,
  output logic             bit_start,
  output logic             tx_pt,
  output logic             sample_pt
  ,output logic            cfg_err
);
  localparam logic [QW-1:0] TX_IDX = QW'(SYNC_Q);

  btg_cfg_t      cfg_q;
  logic          cfg_valid;
  logic          run;
  logic          q_first, q_last;
  logic [QW-1:0] q_idx;
  logic [QW-1:0] sample_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!enable) begin
      cfg_q.brp <= cfg_word[BRP_LSB +: BRP_W];
      cfg_q.ts1 <= cfg_word[TS1_LSB +: TS1_W];
      cfg_q.ts2 <= cfg_word[TS2_LSB +: TS2_W];
    end
  end

  btg_cfg_chk u_chk_cfg (
    .cfg   (cfg_q),
    .valid (cfg_valid)
  );

  assign run = enable && cfg_valid;

  btg_prescaler u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .brp     (cfg_q.brp),
    .q_first (q_first),
    .q_last  (q_last)
  );

  btg_seg_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .q_last (q_last),
    .ts1    (cfg_q.ts1),
    .ts2    (cfg_q.ts2),
    .q_idx  (q_idx)
  );

  assign sample_idx = QW'(SYNC_Q + 1) + QW'(cfg_q.ts1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tq_tick   <= 1'b0;
      bit_start <= 1'b0;
      tx_pt     <= 1'b0;
      sample_pt <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      tq_tick   <= q_first;
      bit_start <= q_first && (q_idx == '0);
      tx_pt     <= q_first && (q_idx == TX_IDX);
      sample_pt <= q_first && (q_idx == sample_idx);
      cfg_err   <= !cfg_valid;
    end
  end
endmodule

// File: rtl/can_bit_timing_checker.sv
module can_bit_timing_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic tq_tick,
  input logic bit_start,
  input logic tx_pt,
  input logic sample_pt,
  input logic cfg_err
);
  AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    tq_tick |=> !tq_tick); // R1

  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> tq_tick); // R3

  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sample_pt |-> tq_tick); // R4

  AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tx_pt |-> tq_tick); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !(tq_tick || bit_start || tx_pt || sample_pt)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !(tq_tick || bit_start || tx_pt || sample_pt)); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_start, tx_pt, sample_pt})); // R9

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_LOW: assert (!(tq_tick || bit_start || tx_pt || sample_pt)); // R9
    end
  end
endmodule

bind can_bit_timing can_bit_timing_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .tq_tick   (tq_tick),
  .bit_start (bit_start),
  .tx_pt     (tx_pt),
  .sample_pt (sample_pt),
  .cfg_err   (cfg_err)
);

// File: tb/can_bit_timing_bench.sv
module can_bit_timing_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        tq_tick, bit_start, tx_pt, sample_pt, cfg_err;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  can_bit_timing u_can_bit_timing (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cfg_word  (cfg_word),
    .tq_tick   (tq_tick),
    .bit_start (bit_start),
    .tx_pt     (tx_pt),
    .sample_pt (sample_pt),
    .cfg_err   (cfg_err)
  );

  typedef struct packed {
    logic [5:0]  brp;
    logic [3:0]  t1;
    logic [2:0]  t2;
    logic        ok;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  4'd4,  3'd3, 1'b1, 16'd20},
    '{6'd1,  4'd3,  3'd2, 1'b1, 16'd32},
    '{6'd0,  4'd15, 3'd7, 1'b1, 16'd50},
    '{6'd2,  4'd3,  3'd1, 1'b1, 16'd42},
    '{6'd0,  4'd3,  3'd1, 1'b0, 16'd0},
    '{6'd3,  4'd5,  3'd5, 1'b0, 16'd0},
    '{6'd1,  4'd2,  3'd1, 1'b0, 16'd0},
    '{6'd1,  4'd8,  3'd0, 1'b0, 16'd0},
    '{6'd5,  4'd6,  3'd2, 1'b1, 16'd132},
    '{6'd63, 4'd3,  3'd2, 1'b1, 16'd1024}
  };

  function automatic logic [15:0] mk_cfg(input logic [5:0] p, input logic [3:0] a, input logic [2:0] b);
    logic [15:0] w;
    w = '0;
    w[5:0]   = p;
    w[11:8]  = a;
    w[14:12] = b;
    return w;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs the grid and records event times relative to the first bit_start.
  int t_bit0, t_bit1, t_tx, t_smp, t_tick1, n_strobes;
  task automatic observe(input int ncyc);
    t_bit0 = -1; t_bit1 = -1; t_tx = -1; t_smp = -1; t_tick1 = -1; n_strobes = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (tq_tick || bit_start || tx_pt || sample_pt) n_strobes++;
      if (bit_start) begin
        if (t_bit0 < 0) t_bit0 = c;
        else if (t_bit1 < 0) t_bit1 = c;
      end
      if (t_bit0 >= 0 && c > t_bit0 && tq_tick && t_tick1 < 0) t_tick1 = c;
      if (t_bit0 >= 0 && tx_pt && t_tx < 0) t_tx = c;
      if (t_bit0 >= 0 && sample_pt && t_smp < 0) t_smp = c;
    end
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk);
    enable   = 1'b0;
    cfg_word = w;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    // R9: outputs during reset
    repeat (4) @(negedge clk);
    check("R9 reset strobes", int'(tq_tick | bit_start | tx_pt | sample_pt), 0);
    check("R9 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;

    // Table sweep: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      int q;
      q = 2 * (int'(VECS[i].brp) + 1);
      load(mk_cfg(VECS[i].brp, VECS[i].t1, VECS[i].t2));
      check("R6 cfg_err", int'(cfg_err), int'(!VECS[i].ok));
      enable = 1'b1;
      if (VECS[i].ok) begin
        observe(2 * int'(VECS[i].per) + 10);
        check("R3 bit period", t_bit1 - t_bit0, int'(VECS[i].per));
        check("R1 tick spacing", t_tick1 - t_bit0, q);
        check("R5 tx offset", t_tx - t_bit0, q);
        check("R4 sample offset", t_smp - t_bit0, q * (int'(VECS[i].t1) + 2));
        check("R2 second segment", t_bit1 - t_smp, q * (int'(VECS[i].t2) + 1));
      end else begin
        observe(200);
        check("R7 invalid quiet", n_strobes, 0);
        check("R6 cfg_err held", int'(cfg_err), 1);
      end
    end

    // R7: disabled with a valid configuration keeps strobes low
    load(mk_cfg(6'd0, 4'd4, 3'd3));
    observe(60);
    check("R7 disabled quiet", n_strobes, 0);

    // R8: writing cfg_word while running is ignored
    enable = 1'b1;
    repeat (5) @(negedge clk);
    cfg_word = mk_cfg(6'd0, 4'd3, 3'd1);
    observe(60);
    check("R8 period kept", t_bit1 - t_bit0, 20);
    check("R8 cfg_err kept", int'(cfg_err), 0);
    cfg_word = mk_cfg(6'd63, 4'd3, 3'd2);
    observe(60);
    check("R8 period kept again", t_bit1 - t_bit0, 20);

    // R8: after disabling, the pending word is taken
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    observe(2100);
    check("R8 new period", t_bit1 - t_bit0, 1024);

    // R6: boundary, B=1 with nonzero divider, A just above B
    load(mk_cfg(6'd1, 4'd3, 3'd1));
    check("R6 B=1 P=1 valid", int'(cfg_err), 0);
    load(mk_cfg(6'd0, 4'd7, 3'd7));
    check("R6 A equal B invalid", int'(cfg_err), 1);

    summary();
    $finish;
  end
endmodule